// File: doc/BRIEF.md
# Triggered block data transfer controller

This block copies data from one memory location to another without processor help. It serves 24 channels. Each channel holds its own descriptor: a block length, a remaining-activation count, a source pointer, a destination pointer and two addressing-mode bits. A one-cycle pulse on a channel's trigger line queues that channel. When the engine is free, it takes the lowest-numbered queued channel. It then copies that channel's whole block one byte at a time over a byte-wide memory port. Each byte is one read followed by one write.

At the end of a block, the engine writes the moved pointers and the reduced count back into the descriptor. The next trigger therefore continues where the last block stopped. When an activation takes the count down to zero, the engine raises that channel's interrupt line for one cycle. The channel then ignores triggers until its count is written again. Software fills the descriptors through a simple write-only port that selects a channel and a field.

Top module: `blk_xfer_ctrl`

## Requirements
- R1: During reset and after it, no memory access and no interrupt occur. Every channel starts exhausted, so triggers have no effect until that channel's count field is written.
- R2: One activation moves N bytes, where N is the channel's block-length field (1 to 255) and the value 0 means 256. Each byte is a read of the current source address, then a write of that same byte to the current destination address. `mem_rd` and `mem_wr` are never high together.
- R3: Control field bit 0 set makes the source pointer step by +1 after each byte. When it is clear, the source pointer stays fixed.
- R4: Control field bit 1 set makes the destination pointer step by +1 after each byte. When it is clear, the destination pointer stays fixed.
- R5: At the end of an activation, the descriptor holds the updated pointers: start+N if stepping, start if fixed. The next activation continues from there.
- R6: Each activation lowers the count by one. A count field of 0 means 256 activations. The activation that leaves the count at zero pulses `irq[ch]` for exactly one cycle, in the cycle after its last write is accepted.
- R7: A trigger for a channel whose count has reached zero is dropped. This holds until software writes that channel's count field again.
- R8: Triggers that arrive while a block is in progress stay queued. Queued channels are served in ascending channel number, one activation per trigger.
- R9: A memory access with `mem_rdy` low is held the next cycle with the same strobe and the same address.
- R10: Writes to the reload field (field code 2) are accepted but change no later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | NUM_CH | One-cycle trigger per channel |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_ch | input | $clog2(NUM_CH) | Channel selected for the write |
| cfg_sel | input | 3 | Field code: 0 block length, 1 count, 2 reload, 3 source, 4 destination, 5 control |
| cfg_wdata | input | ADDR_W | Field value (low bits for length, count and control) |
| mem_rd | output | 1 | Byte read strobe |
| mem_wr | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte address of the current access |
| mem_wdata | output | 8 | Byte being written |
| mem_rdata | input | 8 | Byte returned by the read |
| mem_rdy | input | 1 | Current access completes at this edge |
| irq | output | NUM_CH | One-cycle completion interrupt per channel |

## Verification
The hardest case to reach is the count value 0 standing for 256 activations. The bench must trigger the same channel 256 times and show that the interrupt stays low through the first 255 and fires only on the last. It must then show that one more trigger is dropped. The stimulus uses a one-byte block with a fixed source and a stepping destination, so every activation lands at a new address that the cycle-level model predicts. The queue ordering case is reached by triggering four channels at once, the active one among them, while a long block runs under random `mem_rdy` stalls.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } xfer_state_e;

  localparam logic [2:0] FLD_SIZE   = 3'd0;
  localparam logic [2:0] FLD_COUNT  = 3'd1;
  localparam logic [2:0] FLD_RELOAD = 3'd2;
  localparam logic [2:0] FLD_SRC    = 3'd3;
  localparam logic [2:0] FLD_DST    = 3'd4;
  localparam logic [2:0] FLD_CTRL   = 3'd5;

endpackage

// File: rtl/blk_xfer_arb.sv
module blk_xfer_arb #(
  parameter int NUM_CH = 24,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  output logic              gnt_valid,
  output logic [CH_W-1:0]   gnt_idx
);

  // lowest channel number wins
  always_comb begin
    gnt_valid = |req;
    gnt_idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = CH_W'(i);
    end
  end

endmodule

// File: rtl/blk_xfer_desc.sv
module blk_xfer_desc
  import blk_xfer_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              wb_en,
  input  logic [CH_W-1:0]   wb_ch,
  input  logic [ADDR_W-1:0] wb_src,
  input  logic [ADDR_W-1:0] wb_dst,
  input  logic [CNT_W-1:0]  wb_cnt,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [SIZE_W-1:0] rd_size,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic              rd_src_inc,
  output logic              rd_dst_inc,
  output logic [NUM_CH-1:0] exh_vec,
  output logic [NUM_CH-1:0] exh_nxt
);

  logic [SIZE_W-1:0] size_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];
  logic [ADDR_W-1:0] src_a  [NUM_CH];
  logic [ADDR_W-1:0] dst_a  [NUM_CH];
  logic [NUM_CH-1:0] sinc_v;
  logic [NUM_CH-1:0] dinc_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [SIZE_W-1:0] size_q, size_d;
    logic [CNT_W-1:0]  cnt_q,  cnt_d;
    logic [ADDR_W-1:0] src_q,  src_d;
    logic [ADDR_W-1:0] dst_q,  dst_d;
    logic              sinc_q, sinc_d;
    logic              dinc_q, dinc_d;
    logic              exh_q,  exh_d;
    logic              hit_cfg, hit_wb, ld_en;

    assign hit_cfg = cfg_we && (cfg_ch == CH_W'(i));
    assign hit_wb  = wb_en  && (wb_ch  == CH_W'(i));
    assign ld_en   = hit_cfg || hit_wb;

    always_comb begin
      size_d = size_q;
      cnt_d  = cnt_q;
      src_d  = src_q;
      dst_d  = dst_q;
      sinc_d = sinc_q;
      dinc_d = dinc_q;
      exh_d  = exh_q;
      if (hit_cfg) begin
        case (cfg_sel)
          FLD_SIZE:  size_d = cfg_wdata[SIZE_W-1:0];
          FLD_COUNT: begin
            cnt_d = cfg_wdata[CNT_W-1:0];
            exh_d = 1'b0;
          end
          FLD_SRC:   src_d = cfg_wdata;
          FLD_DST:   dst_d = cfg_wdata;
          FLD_CTRL:  begin
            sinc_d = cfg_wdata[0];
            dinc_d = cfg_wdata[1];
          end
          default: ; // reload field and unused codes are dropped
        endcase
      end
      if (hit_wb) begin
        src_d = wb_src;
        dst_d = wb_dst;
        cnt_d = wb_cnt;
        exh_d = (wb_cnt == '0);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q <= '0;
        cnt_q  <= '0;
        src_q  <= '0;
        dst_q  <= '0;
        sinc_q <= 1'b0;
        dinc_q <= 1'b0;
        exh_q  <= 1'b1;
      end else if (ld_en) begin
        size_q <= size_d;
        cnt_q  <= cnt_d;
        src_q  <= src_d;
        dst_q  <= dst_d;
        sinc_q <= sinc_d;
        dinc_q <= dinc_d;
        exh_q  <= exh_d;
      end
    end

    assign size_a[i]  = size_q;
    assign cnt_a[i]   = cnt_q;
    assign src_a[i]   = src_q;
    assign dst_a[i]   = dst_q;
    assign sinc_v[i]  = sinc_q;
    assign dinc_v[i]  = dinc_q;
    assign exh_vec[i] = exh_q;
    assign exh_nxt[i] = exh_d;
  end

  assign rd_size    = size_a[rd_ch];
  assign rd_cnt     = cnt_a[rd_ch];
  assign rd_src     = src_a[rd_ch];
  assign rd_dst     = dst_a[rd_ch];
  assign rd_src_inc = sinc_v[rd_ch];
  assign rd_dst_inc = dinc_v[rd_ch];

endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 8,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   start_ch,
  input  logic [SIZE_W-1:0] d_size,
  input  logic [CNT_W-1:0]  d_cnt,
  input  logic [ADDR_W-1:0] d_src,
  input  logic [ADDR_W-1:0] d_dst,
  input  logic              d_src_inc,
  input  logic              d_dst_inc,
  output logic              idle,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rdy,
  output logic              wb_en,
  output logic [CH_W-1:0]   wb_ch,
  output logic [ADDR_W-1:0] wb_src,
  output logic [ADDR_W-1:0] wb_dst,
  output logic [CNT_W-1:0]  wb_cnt
);

  localparam int LEFT_W = SIZE_W + 1;
  localparam logic [LEFT_W-1:0] FULL_BLK = LEFT_W'(1) << SIZE_W;

  xfer_state_e       state_q, state_d;
  logic [CH_W-1:0]   ch_q,   ch_d;
  logic [ADDR_W-1:0] src_q,  src_d;
  logic [ADDR_W-1:0] dst_q,  dst_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic              sinc_q, sinc_d;
  logic              dinc_q, dinc_d;
  logic [7:0]        data_q, data_d;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    src_d   = src_q;
    dst_d   = dst_q;
    left_d  = left_q;
    cnt_d   = cnt_q;
    sinc_d  = sinc_q;
    dinc_d  = dinc_q;
    data_d  = data_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          ch_d    = start_ch;
          src_d   = d_src;
          dst_d   = d_dst;
          left_d  = (d_size == '0) ? FULL_BLK : {1'b0, d_size};
          cnt_d   = d_cnt;
          sinc_d  = d_src_inc;
          dinc_d  = d_dst_inc;
          state_d = ST_RD;
        end
      end
      ST_RD: begin
        if (mem_rdy) begin
          data_d  = mem_rdata;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (mem_rdy) begin
          if (sinc_q) src_d = src_q + ADDR_W'(1);
          if (dinc_q) dst_d = dst_q + ADDR_W'(1);
          left_d  = left_q - LEFT_W'(1);
          state_d = (left_q == LEFT_W'(1)) ? ST_DONE : ST_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      left_q  <= left_d;
      cnt_q   <= cnt_d;
      sinc_q  <= sinc_d;
      dinc_q  <= dinc_d;
      data_q  <= data_d;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign mem_rd    = (state_q == ST_RD);
  assign mem_wr    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;
  assign wb_en     = (state_q == ST_DONE);
  assign wb_ch     = ch_q;
  assign wb_src    = src_q;
  assign wb_dst    = dst_q;
  assign wb_cnt    = cnt_q - CNT_W'(1);

endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl #(
  parameter int NUM_CH = 24,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          act_req,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_CH)-1:0]  cfg_ch,
  input  logic [2:0]                 cfg_sel,
  input  logic [ADDR_W-1:0]          cfg_wdata,
  output logic                       mem_rd,
  output logic                       mem_wr,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [7:0]                 mem_wdata,
  input  logic [7:0]                 mem_rdata,
  input  logic                       mem_rdy,
  output logic [NUM_CH-1:0]          irq
);

  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] exh_vec, exh_nxt, eligible, start_mask;
  logic              gnt_valid, eng_idle, start;
  logic [CH_W-1:0]   gnt_idx;
  logic [SIZE_W-1:0] d_size;
  logic [CNT_W-1:0]  d_cnt;
  logic [ADDR_W-1:0] d_src, d_dst;
  logic              d_src_inc, d_dst_inc;
  logic              wb_en;
  logic [CH_W-1:0]   wb_ch;
  logic [ADDR_W-1:0] wb_src, wb_dst;
  logic [CNT_W-1:0]  wb_cnt;

  assign eligible = pend_q & ~exh_vec;
  assign start    = eng_idle && gnt_valid;

  blk_xfer_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) arb_i (
    .req       (eligible),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  blk_xfer_desc #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .CH_W(CH_W)
  ) desc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_ch     (cfg_ch),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .wb_en      (wb_en),
    .wb_ch      (wb_ch),
    .wb_src     (wb_src),
    .wb_dst     (wb_dst),
    .wb_cnt     (wb_cnt),
    .rd_ch      (gnt_idx),
    .rd_size    (d_size),
    .rd_cnt     (d_cnt),
    .rd_src     (d_src),
    .rd_dst     (d_dst),
    .rd_src_inc (d_src_inc),
    .rd_dst_inc (d_dst_inc),
    .exh_vec    (exh_vec),
    .exh_nxt    (exh_nxt)
  );

  blk_xfer_engine #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .CH_W(CH_W)
  ) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_ch  (gnt_idx),
    .d_size    (d_size),
    .d_cnt     (d_cnt),
    .d_src     (d_src),
    .d_dst     (d_dst),
    .d_src_inc (d_src_inc),
    .d_dst_inc (d_dst_inc),
    .idle      (eng_idle),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rdy   (mem_rdy),
    .wb_en     (wb_en),
    .wb_ch     (wb_ch),
    .wb_src    (wb_src),
    .wb_dst    (wb_dst),
    .wb_cnt    (wb_cnt)
  );

  always_comb begin
    start_mask = '0;
    if (start) start_mask[gnt_idx] = 1'b1;
    irq = '0;
    if (wb_en && (wb_cnt == '0)) irq[wb_ch] = 1'b1;
  end

  // queue triggers; exhausted channels drop theirs
  assign pend_d = ((pend_q & ~start_mask) | act_req) & ~exh_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
  parameter int NUM_CH = 24,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_rdy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NUM_CH-1:0] irq
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!mem_rd && !mem_wr && (irq == '0));
    end
  end

  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_wr_after_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_rd && mem_rdy));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_rdy) |=> (mem_wr && $stable(mem_addr)));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  assert_irq_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> $past(mem_wr && mem_rdy));

endmodule

bind blk_xfer_ctrl blk_xfer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_rdy  (mem_rdy),
  .mem_addr (mem_addr),
  .irq      (irq)
);

// File: tb/blk_xfer_ctrl_tb_top.sv
module blk_xfer_ctrl_tb_top;

  localparam int NUM_CH = 24;
  localparam int ADDR_W = 16;
  localparam int CH_W   = 5;

  logic              clk;
  logic              rst_n;
  logic [NUM_CH-1:0] act_req;
  logic              cfg_we;
  logic [CH_W-1:0]   cfg_ch;
  logic [2:0]        cfg_sel;
  logic [ADDR_W-1:0] cfg_wdata;
  logic              mem_rd, mem_wr, mem_rdy;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic [NUM_CH-1:0] irq;

  blk_xfer_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .act_req(act_req),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = pat(mem_addr);

  // memory stall pattern
  logic [7:0] lfsr;
  bit         stall_en;
  initial begin lfsr = 8'h01; stall_en = 0; mem_rdy = 1'b1; end
  always @(posedge clk) begin
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy <= stall_en ? lfsr[0] : 1'b1;
  end

  // reference model state
  int m_size [NUM_CH];
  int m_cnt  [NUM_CH];
  int m_src  [NUM_CH];
  int m_dst  [NUM_CH];
  bit m_sinc [NUM_CH];
  bit m_dinc [NUM_CH];
  bit m_exh  [NUM_CH];
  bit [NUM_CH-1:0] m_pend;
  int    q_kind[$];
  int    q_addr[$];
  int    q_data[$];
  int    q_irq[$];
  string q_tag[$];
  int irq_exp_ch;
  int checks, errors, unexp, cyc;
  bit fin;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic model_start(input int ch);
    int n, s, d;
    n = (m_size[ch] == 0) ? 256 : m_size[ch];
    s = m_src[ch];
    d = m_dst[ch];
    for (int k = 0; k < n; k++) begin
      q_kind.push_back(0); q_addr.push_back(s); q_data.push_back(0);
      q_irq.push_back(-1); q_tag.push_back(m_sinc[ch] ? "R3 R5 src step" : "R3 R5 src fixed");
      q_kind.push_back(1); q_addr.push_back(d); q_data.push_back(int'(pat(16'(s))));
      q_irq.push_back((k == n - 1 && m_cnt[ch] == 1) ? ch : -1);
      q_tag.push_back(m_dinc[ch] ? "R4 R5 dst step" : "R4 R5 dst fixed");
      if (m_sinc[ch]) s = (s + 1) & 16'hFFFF;
      if (m_dinc[ch]) d = (d + 1) & 16'hFFFF;
    end
    m_src[ch] = s;
    m_dst[ch] = d;
    m_cnt[ch] = m_cnt[ch] - 1;
    if (m_cnt[ch] == 0) m_exh[ch] = 1;
  endtask

  // cycle-by-cycle comparison
  logic [NUM_CH-1:0] expv;
  int nxt_irq;
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      expv = '0;
      if (irq_exp_ch >= 0) expv[irq_exp_ch] = 1'b1;
      if (irq_exp_ch >= 0 || irq != '0) chk(irq == expv, "R6", "irq pulse", irq, expv);
      else if (irq !== '0) chk(0, "R6", "irq unknown", irq, 0);
      nxt_irq = -1;
      if (mem_rd && mem_wr) chk(0, "R2", "read and write together", 1, 0);
      else if (mem_rd || mem_wr) begin
        if (q_kind.size() == 0) begin
          unexp++;
          chk(0, "R7/R8", "unexpected access at address", mem_addr, 0);
        end else begin
          chk(int'(mem_wr) == q_kind[0], "R2", "access kind", mem_wr, q_kind[0]);
          chk(int'(mem_addr) == q_addr[0], q_tag[0], "address", mem_addr, q_addr[0]);
          if (mem_wr) chk(int'(mem_wdata) == q_data[0], "R2", "write data", mem_wdata, q_data[0]);
          if (mem_rdy) begin
            nxt_irq = q_irq[0];
            void'(q_kind.pop_front()); void'(q_addr.pop_front());
            void'(q_data.pop_front()); void'(q_irq.pop_front());
            void'(q_tag.pop_front());
          end
        end
      end
      irq_exp_ch = nxt_irq;
      if (q_kind.size() == 0 && m_pend != '0) begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (m_pend[c]) begin
            m_pend[c] = 1'b0;
            model_start(c);
            break;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  task automatic cfg(input int ch, input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_sel = 3'(sel); cfg_wdata = ADDR_W'(val);
    case (sel)
      0: m_size[ch] = val & 255;
      1: begin m_cnt[ch] = ((val & 255) == 0) ? 256 : (val & 255); m_exh[ch] = 0; end
      3: m_src[ch] = val & 16'hFFFF;
      4: m_dst[ch] = val & 16'hFFFF;
      5: begin m_sinc[ch] = val[0]; m_dinc[ch] = val[1]; end
      default: ; // R10: reload field has no effect on the model
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input int sz, input int cnt,
                       input int s, input int d, input int ctl);
    cfg(ch, 0, sz); cfg(ch, 1, cnt); cfg(ch, 3, s); cfg(ch, 4, d); cfg(ch, 5, ctl);
  endtask

  task automatic trig(input logic [NUM_CH-1:0] mask);
    @(negedge clk);
    act_req = mask;
    for (int c = 0; c < NUM_CH; c++) if (mask[c] && !m_exh[c]) m_pend[c] = 1'b1;
    @(negedge clk);
    act_req = '0;
  endtask

  task automatic drain();
    while (q_kind.size() != 0 || m_pend != '0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; unexp = 0; cyc = 0; fin = 0; irq_exp_ch = -1;
    m_pend = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m_size[c] = 0; m_cnt[c] = 0; m_src[c] = 0; m_dst[c] = 0;
      m_sinc[c] = 0; m_dinc[c] = 0; m_exh[c] = 1;
    end
    rst_n = 1'b0; act_req = '0; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
    chk(irq == '0, "R1", "irq in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_rd && !mem_wr, "R1", "strobes after reset", {mem_rd, mem_wr}, 0);
    // R1: unprogrammed channels drop triggers
    trig('1);
    drain();
    chk(unexp == 0, "R1", "accesses from unprogrammed channels", unexp, 0);

    // R2 R3 R4 R5: stepping both, two activations, reload write in between (R10)
    setup(3, 4, 2, 16'h0100, 16'h0200, 3);
    trig(24'(1) << 3);
    drain();
    cfg(3, 2, 16'h0055);
    trig(24'(1) << 3);
    drain();
    // R7: exhausted channel ignores trigger
    trig(24'(1) << 3);
    drain();
    chk(unexp == 0, "R7", "accesses after count reached zero", unexp, 0);
    chk(m_exh[3] == 1, "R7", "model exhausted", m_exh[3], 1);
    cfg(3, 1, 1);
    trig(24'(1) << 3);
    drain();

    // R3 R4: fixed/stepping combinations
    setup(5, 3, 1, 16'h0300, 16'h0400, 2);
    setup(6, 3, 1, 16'h0500, 16'h0600, 1);
    setup(7, 3, 1, 16'h0700, 16'h0800, 0);
    trig(24'(1) << 5); drain();
    trig(24'(1) << 6); drain();
    trig(24'(1) << 7); drain();

    // R8 R9: queueing and ascending order under stalls
    stall_en = 1;
    setup(10, 16, 3, 16'h1000, 16'h1100, 3);
    setup(12, 2, 1, 16'h1200, 16'h1300, 3);
    setup(15, 2, 1, 16'h1500, 16'h1600, 1);
    setup(20, 2, 1, 16'h2000, 16'h2100, 2);
    trig(24'(1) << 10);
    repeat (6) @(negedge clk);
    chk(q_kind.size() != 0, "R8", "block still running when triggers arrive", q_kind.size(), 1);
    trig((24'(1) << 10) | (24'(1) << 12) | (24'(1) << 15) | (24'(1) << 20));
    drain();
    chk(unexp == 0, "R8", "accesses outside expected order", unexp, 0);

    // R2: block length 0 means 256 bytes, with stalls (R9)
    setup(0, 0, 1, 16'h4000, 16'h5000, 3);
    trig(24'(1));
    drain();
    stall_en = 0;

    // R6: count 0 means 256 activations, irq only on the last
    setup(23, 1, 0, 16'h6000, 16'h7000, 2);
    for (int k = 0; k < 256; k++) begin
      trig(24'(1) << 23);
      drain();
    end
    chk(m_exh[23] == 1, "R6", "exhausted after 256 activations", m_exh[23], 1);
    trig(24'(1) << 23);
    drain();
    chk(unexp == 0, "R7", "accesses after 256th activation", unexp, 0);
    chk(q_kind.size() == 0, "R6", "all expected accesses seen", q_kind.size(), 0);
    report();
  end

endmodule